// File: doc/BRIEF.md
# Two-Mode Helper Device Command Register

This block is a single byte-wide host register that works in two modes. In select mode the host picks which on-chip helper is attached to the register: nothing, a serial identity-bit reader, or an analog monitor converter. In device mode the same address becomes the control and status window of the attached helper. A write with bit 7 set always brings the register back to select mode, so the host can recover from any state with one write.

The controller has four named states. ST_SELECT is entered at reset. ST_DEV_NONE, ST_DEV_ID and ST_DEV_ADC are the device-mode views. The transitions are as follows. ENTER_DEV goes from ST_SELECT to the view that the stored device code names, on a write with bit 7 clear. PICK stays in ST_SELECT and loads a new device code, on a write with bits 7 and 6 set. REARM stays in ST_SELECT with the code unchanged, on a write with bit 7 set and bit 6 clear. ESCAPE goes from any device view back to ST_SELECT, on a write with bit 7 set.

In the converter view, the host sees the converter's busy level and two sticky event flags. One flag records a finished conversion and the other a finished sequence, and both clear on the read that returns them. Writes in this view produce one-clock converter reset and start pulses. In the identity view, each read returns the current serial bit and emits a one-clock shift pulse. A write with bit 7 clear emits a one-clock reload pulse to the separate streaming block.

Top module: `devcmd_reg`

## Requirements
- R1: After reset (rst_n low, asynchronous) the register is in ST_SELECT with device code 00, rd_data reads 0x80, and all pulse outputs are 0.
- R2: In ST_SELECT, rd_data has bit 7 = 1, bits 6:2 = 0, and bits 1:0 = the stored device code (00 none, 01 identity reader, 10 converter).
- R3: In ST_SELECT, a write with bits 7 and 6 set loads the device code from wr_data[1:0]. A write with bit 7 set and bit 6 clear leaves the code unchanged.
- R4: In ST_SELECT, a write with bit 7 clear enters the device view for the stored code, and its other data bits change nothing: no pulse is issued and the code is kept.
- R5: In any device view, a write with bit 7 set returns to ST_SELECT, keeps the device code and issues no pulse.
- R6: In ST_DEV_ADC, rd_data bit 6 = adc_busy, bit 1 = conversion-done flag, bit 0 = sequence-done flag, and all other bits are 0.
- R7: The two converter flags are set by an adc_eoc or adc_eos cycle and stay set until a read in ST_DEV_ADC. That read clears them, unless an event for the same flag arrives in that same cycle, in which case the flag stays set.
- R8: In ST_DEV_ADC, a write with bit 7 clear raises adc_reset for exactly the next clock if bit 6 is set, and raises adc_convst for exactly the next clock if bit 0 is set.
- R9: In ST_DEV_ID, rd_data bit 0 = id_bit and the other bits are 0. Each read raises id_shift for the next clock. A write with bit 7 clear raises id_reload for the next clock.
- R10: In ST_DEV_NONE, which is also used for code 11, rd_data reads 0x00 and writes with bit 7 clear have no effect on state or pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low soft reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host read strobe (read side effects) |
| rd_data | output | 8 | Current read value of the register |
| adc_busy | input | 1 | Converter busy level |
| adc_eoc | input | 1 | Converter conversion-done event |
| adc_eos | input | 1 | Converter sequence-done event |
| adc_reset | output | 1 | One-clock converter reset pulse |
| adc_convst | output | 1 | One-clock converter start pulse |
| id_bit | input | 1 | Current serial identity bit |
| id_reload | output | 1 | One-clock identity stream reload pulse |
| id_shift | output | 1 | One-clock identity stream advance pulse |

## Verification
Directed sequences walk every transition: PICK with each device code, REARM with a stray code in the low bits, ENTER_DEV with noisy low bits, and ESCAPE from each view. This separates a decoder that looks only at bit 7 from one that wrongly honours bits 6:0. Converter events are sent alone, during idle stretches and in the very cycle of a clearing read, which separates a correctly sticky flag from one that a read wipes too early. A long pseudo-random stream of strobes, data bytes and events is then compared every clock against a behavioural model, so that mixes of read and write in one cycle and back-to-back pulses are also covered.

// File: rtl/devcmd_pkg.sv
package devcmd_pkg;
    localparam int DATA_W = 8;
    localparam int CODE_W = 2;
    localparam int NFLAG  = 2;

    // bit positions the host decodes
    localparam int B_ESC  = 7;
    localparam int B_CHG  = 6;
    localparam int B_ARST = 6;
    localparam int B_CONV = 0;
    localparam int B_BUSY = 6;
    localparam int B_EOC  = 1;
    localparam int B_EOS  = 0;

    localparam logic [CODE_W-1:0] DEV_NONE = 2'b00;
    localparam logic [CODE_W-1:0] DEV_ID   = 2'b01;
    localparam logic [CODE_W-1:0] DEV_ADC  = 2'b10;

    typedef enum logic [1:0] {
        ST_SELECT   = 2'd0,
        ST_DEV_NONE = 2'd1,
        ST_DEV_ID   = 2'd2,
        ST_DEV_ADC  = 2'd3
    } mode_e;

    function automatic mode_e code_to_mode(input logic [CODE_W-1:0] c);
        if (c == DEV_ID)       return ST_DEV_ID;
        else if (c == DEV_ADC) return ST_DEV_ADC;
        else                   return ST_DEV_NONE;
    endfunction
endpackage

// File: rtl/devcmd_fsm.sv
module devcmd_fsm
    import devcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_esc,
    input  logic              wr_chg,
    input  logic [CODE_W-1:0] wr_code,
    output mode_e             mode,
    output logic [CODE_W-1:0] dev_code
);
    mode_e             mode_nxt;
    logic [CODE_W-1:0] code_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode     <= ST_SELECT;
            dev_code <= DEV_NONE;
        end else begin
            mode     <= mode_nxt;
            dev_code <= code_nxt;
        end
    end

    // transitions: PICK, REARM, ENTER_DEV, ESCAPE
    always_comb begin
        mode_nxt = mode;
        code_nxt = dev_code;
        if (wr_en) begin
            unique case (mode)
                ST_SELECT: begin
                    if (wr_esc) begin
                        if (wr_chg) code_nxt = wr_code;   // PICK
                    end else begin
                        mode_nxt = code_to_mode(dev_code); // ENTER_DEV
                    end
                end
                ST_DEV_NONE, ST_DEV_ID, ST_DEV_ADC: begin
                    if (wr_esc) mode_nxt = ST_SELECT;      // ESCAPE
                end
                default: mode_nxt = ST_SELECT;
            endcase
        end
    end
endmodule

// File: rtl/devcmd_adc_view.sv
module devcmd_adc_view
    import devcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            mode,
    input  logic             wr_en,
    input  logic             wr_esc,
    input  logic             wr_arst,
    input  logic             wr_conv,
    input  logic             rd_en,
    input  logic             ev_eoc,
    input  logic             ev_eos,
    output logic [NFLAG-1:0] flags,
    output logic             adc_reset,
    output logic             adc_convst
);
    localparam int I_EOS = 0;
    localparam int I_EOC = 1;

    logic [NFLAG-1:0] ev;
    logic             in_view;
    logic             clr;
    logic             cmd;

    assign ev      = {ev_eoc, ev_eos};
    assign in_view = (mode == ST_DEV_ADC);
    assign clr     = rd_en && in_view;
    assign cmd     = wr_en && in_view && !wr_esc;

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (ev[i])  flags[i] <= 1'b1;
            else if (clr)    flags[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adc_reset  <= 1'b0;
            adc_convst <= 1'b0;
        end else begin
            adc_reset  <= cmd && wr_arst;
            adc_convst <= cmd && wr_conv;
        end
    end

    logic unused_idx;
    assign unused_idx = (I_EOS == I_EOC);
endmodule

// File: rtl/devcmd_id_view.sv
module devcmd_id_view
    import devcmd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode,
    input  logic  wr_en,
    input  logic  wr_esc,
    input  logic  rd_en,
    output logic  id_reload,
    output logic  id_shift
);
    logic in_view;
    assign in_view = (mode == ST_DEV_ID);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_reload <= 1'b0;
            id_shift  <= 1'b0;
        end else begin
            id_reload <= wr_en && !wr_esc && in_view;
            id_shift  <= rd_en && in_view;
        end
    end
endmodule

// File: rtl/devcmd_rdmux.sv
module devcmd_rdmux
    import devcmd_pkg::*;
(
    input  mode_e             mode,
    input  logic [CODE_W-1:0] dev_code,
    input  logic              busy,
    input  logic [NFLAG-1:0]  flags,
    input  logic              id_bit,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        unique case (mode)
            ST_SELECT: begin
                rd_data[B_ESC]        = 1'b1;
                rd_data[CODE_W-1:0]   = dev_code;
            end
            ST_DEV_ID: rd_data[0] = id_bit;
            ST_DEV_ADC: begin
                rd_data[B_BUSY] = busy;
                rd_data[B_EOC]  = flags[1];
                rd_data[B_EOS]  = flags[0];
            end
            ST_DEV_NONE: rd_data = '0;
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/devcmd_reg.sv
module devcmd_reg
    import devcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              adc_busy,
    input  logic              adc_eoc,
    input  logic              adc_eos,
    output logic              adc_reset,
    output logic              adc_convst,
    input  logic              id_bit,
    output logic              id_reload,
    output logic              id_shift
);
    mode_e             mode;
    logic [CODE_W-1:0] dev_code;
    logic [NFLAG-1:0]  flags;

    devcmd_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_esc   (wr_data[B_ESC]),
        .wr_chg   (wr_data[B_CHG]),
        .wr_code  (wr_data[CODE_W-1:0]),
        .mode     (mode),
        .dev_code (dev_code)
    );

    devcmd_adc_view u_adc (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .wr_en      (wr_en),
        .wr_esc     (wr_data[B_ESC]),
        .wr_arst    (wr_data[B_ARST]),
        .wr_conv    (wr_data[B_CONV]),
        .rd_en      (rd_en),
        .ev_eoc     (adc_eoc),
        .ev_eos     (adc_eos),
        .flags      (flags),
        .adc_reset  (adc_reset),
        .adc_convst (adc_convst)
    );

    devcmd_id_view u_id (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .wr_en     (wr_en),
        .wr_esc    (wr_data[B_ESC]),
        .rd_en     (rd_en),
        .id_reload (id_reload),
        .id_shift  (id_shift)
    );

    devcmd_rdmux u_mux (
        .mode     (mode),
        .dev_code (dev_code),
        .busy     (adc_busy),
        .flags    (flags),
        .id_bit   (id_bit),
        .rd_data  (rd_data)
    );

    logic unused_bits;
    assign unused_bits = ^wr_data[5:2];
endmodule

// File: rtl/devcmd_reg_chk.sv
module devcmd_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       adc_reset,
    input logic       adc_convst,
    input logic       id_reload,
    input logic       id_shift
);
    a_r2_select_format: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7] |-> (rd_data[6:2] == 5'd0));

    a_r3_rearm_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7] && !wr_data[6] && rd_data[7])
        |=> (rd_data[1:0] == $past(rd_data[1:0])));

    a_r4_enter_device: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[7] && rd_data[7]) |=> !rd_data[7]);

    a_r5_escape: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7]) |=> rd_data[7]);

    a_r8_reset_cause: assert property (@(posedge clk) disable iff (!rst_n)
        adc_reset |-> ($past(wr_en) && !$past(wr_data[7]) && $past(wr_data[6])));

    a_r8_convst_cause: assert property (@(posedge clk) disable iff (!rst_n)
        adc_convst |-> ($past(wr_en) && !$past(wr_data[7]) && $past(wr_data[0])));

    a_r9_shift_cause: assert property (@(posedge clk) disable iff (!rst_n)
        id_shift |-> $past(rd_en));

    a_r9_reload_cause: assert property (@(posedge clk) disable iff (!rst_n)
        id_reload |-> ($past(wr_en) && !$past(wr_data[7])));
endmodule

bind devcmd_reg devcmd_reg_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .adc_reset  (adc_reset),
    .adc_convst (adc_convst),
    .id_reload  (id_reload),
    .id_shift   (id_shift)
);

// File: tb/devcmd_reg_test.sv
module devcmd_reg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       adc_busy = 1'b0;
    logic       adc_eoc = 1'b0;
    logic       adc_eos = 1'b0;
    logic       adc_reset;
    logic       adc_convst;
    logic       id_bit = 1'b0;
    logic       id_reload;
    logic       id_shift;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;   // 50 MHz

    devcmd_reg uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .adc_busy(adc_busy),
        .adc_eoc(adc_eoc), .adc_eos(adc_eos), .adc_reset(adc_reset),
        .adc_convst(adc_convst), .id_bit(id_bit), .id_reload(id_reload),
        .id_shift(id_shift)
    );

    // behavioural reference: 0 = select, 1 = device view
    int m_mode, m_sel;
    bit m_eoc, m_eos, m_rst, m_cv, m_rl, m_sh;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_sel = 0;
            m_eoc = 0; m_eos = 0;
            m_rst = 0; m_cv = 0; m_rl = 0; m_sh = 0;
        end else begin
            bit in_adc, in_id, clr;
            in_adc = (m_mode == 1) && (m_sel == 2);
            in_id  = (m_mode == 1) && (m_sel == 1);
            clr    = rd_en && in_adc;
            m_rst  = wr_en && in_adc && !wr_data[7] && wr_data[6];
            m_cv   = wr_en && in_adc && !wr_data[7] && wr_data[0];
            m_rl   = wr_en && in_id && !wr_data[7];
            m_sh   = rd_en && in_id;
            m_eoc  = adc_eoc || (m_eoc && !clr);
            m_eos  = adc_eos || (m_eos && !clr);
            if (wr_en) begin
                if (m_mode == 0) begin
                    if (wr_data[7]) begin
                        if (wr_data[6]) m_sel = int'(wr_data[1:0]);
                    end else m_mode = 1;
                end else if (wr_data[7]) m_mode = 0;
            end
        end
    end

    function automatic logic [7:0] model_rd();
        logic [7:0] v = 8'h00;
        if (m_mode == 0) v = 8'h80 | 8'(m_sel);
        else if (m_sel == 1) v[0] = id_bit;
        else if (m_sel == 2) begin
            v[6] = adc_busy; v[1] = m_eoc; v[0] = m_eos;
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string t;
        if (m_mode == 0)      t = "R2";
        else if (m_sel == 1)  t = "R9";
        else if (m_sel == 2)  t = "R6";
        else                  t = "R10";
        chk(t, rd_data, model_rd());
        chk("R8", {7'd0, adc_reset},  {7'd0, m_rst});
        chk("R8", {7'd0, adc_convst}, {7'd0, m_cv});
        chk("R9", {7'd0, id_reload},  {7'd0, m_rl});
        chk("R9", {7'd0, id_shift},   {7'd0, m_sh});
    endtask

    // compare at the falling edge, then drive the next cycle's inputs
    task automatic step(input bit w, input logic [7:0] d, input bit r,
                        input bit e1, input bit e0);
        @(negedge clk);
        compare_all();
        wr_en = w; wr_data = d; rd_en = r; adc_eoc = e1; adc_eos = e0;
    endtask

    task automatic idle();
        step(0, 8'h00, 0, 0, 0);
    endtask

    task automatic wr(input logic [7:0] d);
        step(1, d, 0, 0, 0);
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", rd_data, 8'h80);
        chk("R1", {4'd0, adc_reset, adc_convst, id_reload, id_shift}, 8'h00);

        // PICK converter, REARM with stray code, ENTER_DEV with noisy bits
        wr(8'hC2);  chk("R3", rd_data, 8'h82);
        wr(8'h81);  chk("R3", rd_data, 8'h82);
        wr(8'h3E);  chk("R4", rd_data, 8'h00);
        chk("R4", {6'd0, adc_reset, adc_convst}, 8'h00);

        // converter view
        adc_busy = 1'b1;
        idle();     chk("R6", rd_data, 8'h40);
        adc_busy = 1'b0;
        step(0, 8'h00, 0, 1, 0);
        idle(); idle(); idle();
        chk("R7", rd_data, 8'h02);
        step(0, 8'h00, 1, 0, 0);   // clearing read
        idle();     chk("R7", rd_data, 8'h00);
        step(0, 8'h00, 0, 0, 1);
        step(0, 8'h00, 1, 0, 1);   // read with a fresh event
        idle();     chk("R7", rd_data, 8'h01);
        step(0, 8'h00, 1, 0, 0);
        idle();     chk("R7", rd_data, 8'h00);
        wr(8'h41);  chk("R8", {6'd0, adc_reset, adc_convst}, 8'h03);
        idle();     chk("R8", {6'd0, adc_reset, adc_convst}, 8'h00);
        wr(8'h01);  chk("R8", {6'd0, adc_reset, adc_convst}, 8'h01);
        wr(8'hC1);  chk("R5", rd_data, 8'h82);
        chk("R5", {6'd0, adc_reset, adc_convst}, 8'h00);

        // identity view
        wr(8'hC1);  chk("R3", rd_data, 8'h81);
        wr(8'h00);
        id_bit = 1'b1;
        idle();     chk("R9", rd_data, 8'h01);
        step(0, 8'h00, 1, 0, 0);
        idle();     chk("R9", {7'd0, id_shift}, 8'h01);
        wr(8'h12);  chk("R9", {7'd0, id_reload}, 8'h01);
        wr(8'h80);  chk("R5", rd_data, 8'h81);
        id_bit = 1'b0;

        // no device, and code 11
        wr(8'hC0); wr(8'h00);
        wr(8'h41);  chk("R10", rd_data, 8'h00);
        chk("R10", {4'd0, adc_reset, adc_convst, id_reload, id_shift}, 8'h00);
        wr(8'h80); wr(8'hC3); wr(8'h00);
        step(0, 8'h00, 1, 0, 0);
        idle();     chk("R10", rd_data, 8'h00);

        // pseudo-random mix, compared every clock
        lfsr = 32'h1234_5678;
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] d;
            bit w;
            lfsr = (lfsr << 1) ^ ((lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]) ? 1 : 0);
            d = lfsr[15:8];
            w = (lfsr[3:0] < 4);
            if (w && lfsr[4] && (d[7:6] == 2'b11)) d[1:0] = lfsr[6:5];
            adc_busy = lfsr[20];
            id_bit   = lfsr[22];
            step(w, d, lfsr[17] & lfsr[18], lfsr[24] & lfsr[25] & lfsr[26],
                 lfsr[27] & lfsr[28] & lfsr[29]);
        end
        idle();
        @(negedge clk);
        compare_all();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule